// File: doc/BRIEF.md
# Dual-Panel Display Prefetch Buffer

This block holds display data between a display DMA engine and the pixel pipeline. It has two first-in first-out stores. Each store keeps sixteen 64-bit entries. The DMA side writes one entry per cycle and tags it with a source code: palette load, upper-half pixels or lower-half pixels. The block steers each entry to a store according to the panel mode. An entry is stored exactly as it arrives, so packed pixels stay packed.

In single-panel mode only store 0 is in use. It takes palette data and pixel data, and store 1 sits idle. In dual-panel mode, store 0 takes palette and upper-half traffic, and store 1 takes lower-half traffic.

Each store raises its own service request when at least four entries are free. The DMA engine answers a request with a burst of four entries. A request drops as soon as the first beat of a burst lands and is not raised again until the fourth beat is written. Each store keeps two sticky error flags, overflow and underrun. A flush input empties both stores when the controller is shut down.

Top module: `dpf_prefetch_top`

## Requirements
- R1: After a synchronous reset both fill levels are 0, all overflow and underrun flags are 0, and no fill level ever exceeds 16.
- R2: Each store returns its entries in write order, with all 64 bits unchanged. A pop and a write on the same cycle leave the fill level unchanged. With no write and no pop the level holds.
- R3: Outside a burst, a store's request is high exactly when it is active, flush is low and its fill level is 12 or less.
- R4: A burst is counted as four accepted writes to one store. The store's request is low from the cycle after the first beat until the fourth beat has been written.
- R5: In single-panel mode (`dual_mode`=0), every source code 0, 1 and 2 goes to store 0. Store 1 stays empty and its request stays low.
- R6: In dual-panel mode (`dual_mode`=1), source codes 0 (palette) and 1 (upper half) go to store 0, and code 2 (lower half) goes to store 1. Code 3 is reserved and is dropped in either mode.
- R7: A write to a full store is dropped and sets that store's overflow flag. The flag stays set until reset, including through a flush.
- R8: A pop from an empty store leaves it unchanged and sets that store's underrun flag. The flag stays set until reset.
- R9: While flush is high both requests are low, and writes and pops are ignored without setting any flag. One cycle after flush both stores are empty with no burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dual_mode | input | 1 | 0 = single panel, 1 = dual panel |
| flush | input | 1 | Empties both stores and holds requests low |
| dma_valid | input | 1 | DMA write strobe |
| dma_src | input | 2 | Source code: 0 palette, 1 upper, 2 lower, 3 reserved |
| dma_data | input | 64 | DMA write entry |
| dma_req | output | 2 | Service request, bit n for store n |
| pix_rd | input | 2 | Pop strobe, bit n for store n |
| pix_data0 | output | 64 | Head entry of store 0 |
| pix_data1 | output | 64 | Head entry of store 1 |
| fill_lvl0 | output | 5 | Entries held in store 0 |
| fill_lvl1 | output | 5 | Entries held in store 1 |
| ovf | output | 2 | Sticky overflow flag per store |
| unf | output | 2 | Sticky underrun flag per store |

## Verification
The bench fills store 0 through four full bursts. It then drains the store one entry at a time and checks the request at every fill level. A threshold that is off by one would show up at level 12 or 13, and a request that stays high through a burst would be seen after the first beat.

A same-cycle pop and write on store 1 checks that the level holds and that a burst starts. A design that counts a write only when no pop happens would fail here.

Writes to a full store and pops from an empty one check the sticky flags. Source codes are sent in both modes to catch lower-half traffic that is misrouted or lost in single-panel mode, and a reserved code that gets stored. A flush that arrives together with writes and pops must leave empty stores and no spurious underrun.

// File: rtl/dpf_pkg.sv
package dpf_pkg;

    localparam int unsigned ENTRY_W = 64;
    localparam int unsigned DEPTH   = 16;
    localparam int unsigned BURST   = 4;
    localparam int unsigned NBUF    = 2;

    typedef enum logic [1:0] {
        SRC_PALETTE = 2'd0,
        SRC_UPPER   = 2'd1,
        SRC_LOWER   = 2'd2,
        SRC_RSVD    = 2'd3
    } src_e;

    typedef struct packed {
        logic ovf;
        logic unf;
    } flags_t;

    // One-hot store select for a tagged write; zero means drop.
    function automatic logic [NBUF-1:0] route_target(input logic dual, input src_e src);
        logic [NBUF-1:0] sel;
        sel = '0;
        if (src != SRC_RSVD) begin
            if (dual && src == SRC_LOWER) sel[1] = 1'b1;
            else                          sel[0] = 1'b1;
        end
        return sel;
    endfunction

endpackage

// File: rtl/dpf_router.sv
module dpf_router
    import dpf_pkg::*;
(
    input  logic            dual_mode,
    input  logic            flush,
    input  logic            dma_valid,
    input  logic [1:0]      dma_src,
    output logic [NBUF-1:0] wr_sel
);

    always_comb begin
        if (dma_valid && !flush) wr_sel = route_target(dual_mode, src_e'(dma_src));
        else                     wr_sel = '0;
    end

endmodule

// File: rtl/dpf_buffer.sv
module dpf_buffer
    import dpf_pkg::*;
#(
    parameter int unsigned ENTRY_W = dpf_pkg::ENTRY_W,
    parameter int unsigned DEPTH   = dpf_pkg::DEPTH,
    parameter int unsigned BURST   = dpf_pkg::BURST,
    localparam int unsigned PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned LVL_W  = $clog2(DEPTH + 1),
    localparam int unsigned BEAT_W = (BURST > 1) ? $clog2(BURST) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic               active,
    input  logic               wr_en,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic               rd_en,
    output logic [ENTRY_W-1:0] rd_data,
    output logic [LVL_W-1:0]   level,
    output logic               req,
    output flags_t             flags
);

    logic [ENTRY_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]   wr_ptr, rd_ptr;
    logic [LVL_W-1:0]   lvl_q;
    logic [BEAT_W-1:0]  beat_q;
    flags_t             flg_q;

    logic full, empty, do_wr, do_rd, ovf_ev, unf_ev;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full   = (lvl_q == LVL_W'(DEPTH));
        empty  = (lvl_q == '0);
        do_wr  = wr_en && !full;
        do_rd  = rd_en && !empty && !flush;
        ovf_ev = wr_en && full;
        unf_ev = rd_en && empty && !flush;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            lvl_q  <= '0;
            beat_q <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            lvl_q  <= '0;
            beat_q <= '0;
        end else begin
            if (do_wr) begin
                wr_ptr <= ptr_next(wr_ptr);
                beat_q <= (beat_q == BEAT_W'(BURST - 1)) ? '0 : beat_q + 1'b1;
            end
            if (do_rd) rd_ptr <= ptr_next(rd_ptr);
            case ({do_wr, do_rd})
                2'b10:   lvl_q <= lvl_q + 1'b1;
                2'b01:   lvl_q <= lvl_q - 1'b1;
                default: lvl_q <= lvl_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flg_q <= '0;
        end else begin
            if (ovf_ev) flg_q.ovf <= 1'b1;
            if (unf_ev) flg_q.unf <= 1'b1;
        end
    end

    always_comb begin
        rd_data = mem[rd_ptr];
        level   = lvl_q;
        flags   = flg_q;
        req     = active && !flush && (beat_q == '0)
                  && ((LVL_W'(DEPTH) - lvl_q) >= LVL_W'(BURST));
    end

endmodule

// File: rtl/dpf_prefetch_top.sv
module dpf_prefetch_top
    import dpf_pkg::*;
#(
    parameter int unsigned ENTRY_W = dpf_pkg::ENTRY_W,
    parameter int unsigned DEPTH   = dpf_pkg::DEPTH,
    parameter int unsigned BURST   = dpf_pkg::BURST,
    localparam int unsigned LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               dual_mode,
    input  logic               flush,
    input  logic               dma_valid,
    input  logic [1:0]         dma_src,
    input  logic [ENTRY_W-1:0] dma_data,
    output logic [1:0]         dma_req,
    input  logic [1:0]         pix_rd,
    output logic [ENTRY_W-1:0] pix_data0,
    output logic [ENTRY_W-1:0] pix_data1,
    output logic [LVL_W-1:0]   fill_lvl0,
    output logic [LVL_W-1:0]   fill_lvl1,
    output logic [1:0]         ovf,
    output logic [1:0]         unf
);

    logic [NBUF-1:0]    wr_sel;
    logic [ENTRY_W-1:0] rd_data_a [NBUF];
    logic [LVL_W-1:0]   lvl_a     [NBUF];
    flags_t             flg_a     [NBUF];

    dpf_router i_router (
        .dual_mode (dual_mode),
        .flush     (flush),
        .dma_valid (dma_valid),
        .dma_src   (dma_src),
        .wr_sel    (wr_sel)
    );

    for (genvar g = 0; g < NBUF; g++) begin : g_buf
        logic act;
        assign act = (g == 0) ? 1'b1 : dual_mode;

        dpf_buffer #(
            .ENTRY_W (ENTRY_W),
            .DEPTH   (DEPTH),
            .BURST   (BURST)
        ) i_buf (
            .clk     (clk),
            .rst     (rst),
            .flush   (flush),
            .active  (act),
            .wr_en   (wr_sel[g]),
            .wr_data (dma_data),
            .rd_en   (pix_rd[g]),
            .rd_data (rd_data_a[g]),
            .level   (lvl_a[g]),
            .req     (dma_req[g]),
            .flags   (flg_a[g])
        );

        assign ovf[g] = flg_a[g].ovf;
        assign unf[g] = flg_a[g].unf;
    end

    assign pix_data0 = rd_data_a[0];
    assign pix_data1 = rd_data_a[1];
    assign fill_lvl0 = lvl_a[0];
    assign fill_lvl1 = lvl_a[1];

endmodule

// File: rtl/dpf_prefetch_chk.sv
module dpf_prefetch_chk #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned BURST = 4,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             flush,
    input logic             dual_mode,
    input logic [1:0]       wr_sel,
    input logic [1:0]       dma_req,
    input logic [1:0]       pix_rd,
    input logic [LVL_W-1:0] lvl0,
    input logic [LVL_W-1:0] lvl1,
    input logic [1:0]       ovf,
    input logic [1:0]       unf
);

    // R1
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (lvl0 <= LVL_W'(DEPTH)) && (lvl1 <= LVL_W'(DEPTH)));

    // R2
    level_hold0_chk: assert property (@(posedge clk) disable iff (rst)
        (!flush && !wr_sel[0] && !pix_rd[0]) |=> (lvl0 == $past(lvl0)));

    // R2
    level_hold1_chk: assert property (@(posedge clk) disable iff (rst)
        (!flush && !wr_sel[1] && !pix_rd[1]) |=> (lvl1 == $past(lvl1)));

    // R3
    req_room0_chk: assert property (@(posedge clk) disable iff (rst)
        dma_req[0] |-> (lvl0 <= LVL_W'(DEPTH - BURST)));

    // R3
    req_room1_chk: assert property (@(posedge clk) disable iff (rst)
        dma_req[1] |-> (lvl1 <= LVL_W'(DEPTH - BURST)));

    // R4
    burst_drop0_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_sel[0] && dma_req[0]) |=> !dma_req[0]);

    // R4
    burst_drop1_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_sel[1] && dma_req[1]) |=> !dma_req[1]);

    // R5
    single_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !dual_mode |-> !dma_req[1]);

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf != 2'b00) |=> ((ovf & $past(ovf)) == $past(ovf)));

    // R8
    unf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (unf != 2'b00) |=> ((unf & $past(unf)) == $past(unf)));

    // R9
    flush_req_chk: assert property (@(posedge clk) disable iff (rst)
        flush |-> (dma_req == 2'b00));

    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> ((lvl0 == '0) && (lvl1 == '0)));

endmodule

bind dpf_prefetch_top dpf_prefetch_chk #(
    .DEPTH (DEPTH),
    .BURST (BURST)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .dual_mode (dual_mode),
    .wr_sel    (wr_sel),
    .dma_req   (dma_req),
    .pix_rd    (pix_rd),
    .lvl0      (fill_lvl0),
    .lvl1      (fill_lvl1),
    .ovf       (ovf),
    .unf       (unf)
);

// File: tb/test_dpf_prefetch_top.sv
`timescale 1ns/1ps
module test_dpf_prefetch_top;

    localparam int DEPTH = 16;
    localparam int BURST = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dual_mode = 1'b1;
    logic        flush = 1'b0;
    logic        dma_valid = 1'b0;
    logic [1:0]  dma_src = 2'd0;
    logic [63:0] dma_data = '0;
    logic [1:0]  dma_req;
    logic [1:0]  pix_rd = 2'b00;
    logic [63:0] pix_data0, pix_data1;
    logic [4:0]  fill_lvl0, fill_lvl1;
    logic [1:0]  ovf, unf;

    int n_chk = 0;
    int n_fail = 0;
    int seq = 0;
    logic [63:0] q0 [$];
    logic [63:0] q1 [$];

    always #2.5 clk = ~clk;

    dpf_prefetch_top i_dpf_prefetch_top (
        .clk(clk), .rst(rst), .dual_mode(dual_mode), .flush(flush),
        .dma_valid(dma_valid), .dma_src(dma_src), .dma_data(dma_data),
        .dma_req(dma_req), .pix_rd(pix_rd),
        .pix_data0(pix_data0), .pix_data1(pix_data1),
        .fill_lvl0(fill_lvl0), .fill_lvl1(fill_lvl1),
        .ovf(ovf), .unf(unf)
    );

    function automatic logic [63:0] pat(input int n);
        return {16'hD15A, 16'(n), 32'(n) * 32'h9E3779B9};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One write beat; the model routes it from the requirement text (R5, R6, R7).
    task automatic push(input logic [1:0] src);
        logic [63:0] d;
        int tgt;
        d = pat(seq);
        seq++;
        if (src == 2'd3)                  tgt = -1;
        else if (dual_mode && src == 2'd2) tgt = 1;
        else                              tgt = 0;
        dma_valid = 1'b1;
        dma_src   = src;
        dma_data  = d;
        tick();
        dma_valid = 1'b0;
        if (tgt == 0 && q0.size() < DEPTH) q0.push_back(d);
        if (tgt == 1 && q1.size() < DEPTH) q1.push_back(d);
    endtask

    task automatic pop(input int b);
        logic [63:0] exp;
        if (b == 0) begin
            exp = q0.pop_front();
            check("R2 data order store0", pix_data0, exp);
        end else begin
            exp = q1.pop_front();
            check("R2 data order store1", pix_data1, exp);
        end
        pix_rd[b] = 1'b1;
        tick();
        pix_rd = 2'b00;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [63:0] d;
        repeat (3) tick();
        // R1 reset state
        check("R1 reset lvl0", 64'(fill_lvl0), 64'd0);
        check("R1 reset lvl1", 64'(fill_lvl1), 64'd0);
        check("R1 reset flags", 64'({ovf, unf}), 64'd0);
        rst = 1'b0;
        tick();
        check("R3 idle request dual", 64'(dma_req), 64'b11);

        // R5 single-panel steering
        dual_mode = 1'b0;
        #1;
        check("R5 store1 request low", 64'(dma_req), 64'b01);
        push(2'd0);
        check("R4 request drops after first beat", 64'(dma_req), 64'b00);
        push(2'd1);
        push(2'd2);
        push(2'd1);
        check("R5 store0 holds all", 64'(fill_lvl0), 64'd4);
        check("R5 store1 empty", 64'(fill_lvl1), 64'd0);
        check("R5 request after burst", 64'(dma_req), 64'b01);
        for (int i = 0; i < 4; i++) pop(0);
        check("R2 drained", 64'(fill_lvl0), 64'd0);

        // R3, R4 burst sweep on store 0 in dual mode
        dual_mode = 1'b1;
        #1;
        check("R3 both request", 64'(dma_req), 64'b11);
        for (int k = 0; k < DEPTH / BURST; k++) begin
            for (int j = 0; j < BURST; j++) begin
                push((j % 2 == 0) ? 2'd0 : 2'd1);
                check("R2 level climbs", 64'(fill_lvl0), 64'(k * BURST + j + 1));
                if (j == BURST - 1)
                    check("R3 request after burst", 64'(dma_req[0]),
                          64'((k * BURST + j + 1) <= DEPTH - BURST));
                else
                    check("R4 request low mid-burst", 64'(dma_req[0]), 64'd0);
                check("R6 store1 untouched", 64'({dma_req[1], fill_lvl1}), 64'h20);
            end
        end

        // R7 overflow
        push(2'd1);
        check("R7 full write dropped", 64'(fill_lvl0), 64'd16);
        check("R7 overflow flag", 64'(ovf), 64'b01);

        // R3 drain sweep over every level
        for (int i = DEPTH; i > 0; i--) begin
            check("R3 request vs level", 64'(dma_req[0]), 64'(i <= DEPTH - BURST));
            pop(0);
        end
        check("R3 empty request", 64'(dma_req[0]), 64'd1);

        // R8 underrun
        pix_rd = 2'b01;
        tick();
        pix_rd = 2'b00;
        check("R8 underrun flag", 64'(unf), 64'b01);
        check("R8 level unchanged", 64'(fill_lvl0), 64'd0);
        check("R7 overflow sticky", 64'(ovf), 64'b01);

        // R6 lower half to store 1
        for (int i = 0; i < 4; i++) push(2'd2);
        check("R6 lower to store1", 64'(fill_lvl1), 64'd4);
        check("R6 store0 untouched", 64'(fill_lvl0), 64'd0);
        // same-cycle pop and write on store 1
        d = pat(seq);
        seq++;
        check("R2 head before pop", pix_data1, q1[0]);
        dma_valid = 1'b1; dma_src = 2'd2; dma_data = d; pix_rd = 2'b10;
        tick();
        dma_valid = 1'b0; pix_rd = 2'b00;
        void'(q1.pop_front());
        q1.push_back(d);
        check("R2 pop+write level", 64'(fill_lvl1), 64'd4);
        check("R4 burst started by pop+write", 64'(dma_req[1]), 64'd0);
        for (int i = 0; i < 3; i++) push(2'd2);
        check("R4 burst completes", 64'({dma_req[1], fill_lvl1}), 64'h27);
        push(2'd3);
        check("R6 reserved dropped", 64'({fill_lvl0, fill_lvl1}), 64'h7);
        push(2'd0);
        check("R6 palette to store0", 64'(fill_lvl0), 64'd1);
        while (q1.size() > 0) pop(1);
        check("R2 store1 drained", 64'(fill_lvl1), 64'd0);

        // R9 flush with traffic
        push(2'd1);
        flush = 1'b1; dma_valid = 1'b1; dma_src = 2'd2; pix_rd = 2'b11;
        #1;
        check("R9 requests low in flush", 64'(dma_req), 64'b00);
        tick();
        check("R9 requests low in flush", 64'(dma_req), 64'b00);
        check("R9 levels empty", 64'({fill_lvl0, fill_lvl1}), 64'd0);
        check("R9 no underrun in flush", 64'(unf), 64'b01);
        flush = 1'b0; dma_valid = 1'b0; pix_rd = 2'b00;
        q0.delete();
        q1.delete();
        #1;
        check("R9 requests back", 64'(dma_req), 64'b11);
        check("R7 overflow survives flush", 64'(ovf), 64'b01);
        push(2'd0);
        check("R9 fresh data after flush", pix_data0, q0[0]);

        finish_run();
    end

endmodule